// File: doc/BRIEF.md
# Multi-Stream Timeslot Fill Regulator

This block sits in the transmit path of a multi-stream link that carries four transport streams. The link is cut into transfer units (MTUs) of timeslots. An external allocation table gives each stream a whole number of slots per MTU, which is the ceiling of the stream's true average occupancy. For every slot that the table marks, the block decides whether the slot carries stream data or virtual-channel payload fill. The aim is that the long-run occupancy matches a fractional target in steps of 1/64 of a slot.

Each stream has a 7-bit target. A value from 1 to 63 is the fraction of a slot, in 64ths, that the stream uses beyond its whole slots. A per-stream accumulator adds the target at every MTU start. When the sum reaches 64, the stream's final allocated slot in that MTU carries data and 64 is taken off the sum. Otherwise that final slot carries fill. All other allocated slots carry data. A target of 0 means every allocated slot carries data. A target above 63 means every allocated slot carries fill.

Targets are read from a 32-bit input word. A changed word takes effect only at an MTU start.

Top module: `mst_fill_regulator`

## Requirements
- R1: Targets are taken from the target word as stream 0 = bits 6:0, stream 1 = bits 14:8, stream 2 = bits 22:16 and stream 3 = bits 30:24. Bits 7, 15, 23 and 31 have no effect on any decision or on any accumulator.
- R2: After synchronous reset, every active target is 64 and every accumulator is 0. `dec_vld_o` is low until the first slot is presented.
- R3: A slot presented with `slot_vld_i` high gives `dec_vld_o` high in the next cycle. That cycle also carries the slot's stream on `dec_strm_o` and the decision on `dec_fill_o`, where 1 = fill and 0 = data. Without a slot, `dec_vld_o` is low in the next cycle.
- R4: A change on `tgt_word_i` changes no decision until the next cycle in which `mtu_start_i` is high.
- R5: A stream whose active target is above 63 gets fill in every allocated slot, including its last slot.
- R6: A stream whose active target is 0 gets data in every allocated slot, including its last slot.
- R7: For a target t from 1 to 63, slots not flagged last carry data. At each MTU start the sum acc+t is formed. If the sum is 64 or more, the last slot carries data and acc becomes sum-64. Otherwise the last slot carries fill and acc becomes the sum. The accumulator never exceeds 63.
- R8: At an MTU start, a stream whose 7-bit target field differs from its active target restarts its accumulator from 0 before adding the new target. Unchanged streams keep their accumulator.
- R9: A slot presented in the same cycle as `mtu_start_i` belongs to the new MTU. Its decision uses the newly loaded target and the newly updated accumulator.
- R10: Starting from a cleared accumulator, with target t held for 64 MTUs, the last slot carries data in exactly t of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_word_i | input | 32 | Packed per-stream fractional targets |
| mtu_start_i | input | 1 | First cycle of a new MTU |
| slot_vld_i | input | 1 | An allocated timeslot is presented |
| slot_strm_i | input | 2 | Stream that owns the presented slot |
| slot_last_i | input | 1 | Slot is the owner's final allocated slot in this MTU |
| dec_vld_o | output | 1 | Decision valid |
| dec_strm_o | output | 2 | Stream of the decided slot |
| dec_fill_o | output | 1 | 1 = send fill, 0 = send data |

## Verification
The MTU-boundary update and the slot decision can land in the same cycle. This happens when a slot arrives together with `mtu_start_i` while the target word has just changed. The bench provokes this by writing a target of 0 over a target of 64 and presenting the last slot in the boundary cycle. The decision is judged correct only if it reflects the new target. The same overlap arises with a changed field that restarts the accumulator. There the bench confirms that the last slot's decision is made from the cleared sum and not from the old one.

// File: rtl/fill_reg_pkg.sv
package fill_reg_pkg;

    localparam int NUM_STREAMS = 4;
    localparam int TGT_W       = 7;
    localparam int FIELD_W     = 8;
    localparam int FULL_SLOT   = 64;

    typedef logic [TGT_W-1:0] tgt_t;

    typedef struct packed {
        logic       force_fill;
        logic       last_data;
    } strm_dec_t;

    // Pull one stream's 7-bit target out of the packed word.
    function automatic tgt_t tgt_field(input logic [NUM_STREAMS*FIELD_W-1:0] word,
                                       input int idx);
        return word[idx*FIELD_W +: TGT_W];
    endfunction

endpackage

// File: rtl/fill_tgt_shadow.sv
module fill_tgt_shadow
    import fill_reg_pkg::*;
#(
    parameter int NS = NUM_STREAMS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NS*FIELD_W-1:0]   word_i,
    input  logic                    mtu_start_i,
    output logic [NS-1:0][TGT_W-1:0] act_o,
    output logic [NS-1:0][TGT_W-1:0] nxt_o,
    output logic [NS-1:0]           chg_o
);
    logic [NS-1:0][TGT_W-1:0] act_q;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            chg_o[i] = mtu_start_i && (tgt_field(word_i, i) != act_q[i]);
            nxt_o[i] = mtu_start_i ? tgt_field(word_i, i) : act_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) act_q[i] <= TGT_W'(FULL_SLOT);
        end else if (mtu_start_i) begin
            for (int i = 0; i < NS; i++) act_q[i] <= tgt_field(word_i, i);
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/fill_stream_accum.sv
module fill_stream_accum
    import fill_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mtu_start_i,
    input  tgt_t       tgt_nxt_i,
    input  logic       chg_i,
    output strm_dec_t  dec_nxt_o,
    output tgt_t       acc_o
);
    tgt_t      acc_q, acc_n, base, sum;
    strm_dec_t dec_q, dec_n;

    always_comb begin
        base  = chg_i ? '0 : acc_q;
        sum   = base + tgt_nxt_i;
        acc_n = base;
        dec_n = '{force_fill: 1'b0, last_data: 1'b1};
        if (tgt_nxt_i[TGT_W-1]) begin
            dec_n = '{force_fill: 1'b1, last_data: 1'b0};
        end else if (tgt_nxt_i != '0) begin
            if (sum >= TGT_W'(FULL_SLOT)) begin
                acc_n           = sum - TGT_W'(FULL_SLOT);
                dec_n.last_data = 1'b1;
            end else begin
                acc_n           = sum;
                dec_n.last_data = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            dec_q <= '{force_fill: 1'b1, last_data: 1'b0};
        end else if (mtu_start_i) begin
            acc_q <= acc_n;
            dec_q <= dec_n;
        end
    end

    assign dec_nxt_o = mtu_start_i ? dec_n : dec_q;
    assign acc_o     = acc_q;
endmodule

// File: rtl/fill_slot_decider.sv
module fill_slot_decider
    import fill_reg_pkg::*;
#(
    parameter int NS = NUM_STREAMS,
    localparam int SW = $clog2(NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  strm_dec_t [NS-1:0] dec_i,
    input  logic              slot_vld_i,
    input  logic [SW-1:0]     slot_strm_i,
    input  logic              slot_last_i,
    output logic              dec_vld_o,
    output logic [SW-1:0]     dec_strm_o,
    output logic              dec_fill_o
);
    strm_dec_t sel;
    logic      fill_n;

    always_comb begin
        sel    = dec_i[slot_strm_i];
        fill_n = sel.force_fill || (slot_last_i && !sel.last_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld_o  <= 1'b0;
            dec_strm_o <= '0;
            dec_fill_o <= 1'b0;
        end else begin
            dec_vld_o  <= slot_vld_i;
            dec_strm_o <= slot_strm_i;
            dec_fill_o <= slot_vld_i && fill_n;
        end
    end
endmodule

// File: rtl/mst_fill_regulator.sv
module mst_fill_regulator
    import fill_reg_pkg::*;
#(
    parameter int NS = NUM_STREAMS,
    localparam int SW = $clog2(NS),
    localparam int WW = NS * FIELD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] tgt_word_i,
    input  logic          mtu_start_i,
    input  logic          slot_vld_i,
    input  logic [SW-1:0] slot_strm_i,
    input  logic          slot_last_i,
    output logic          dec_vld_o,
    output logic [SW-1:0] dec_strm_o,
    output logic          dec_fill_o
);
    logic [NS-1:0][TGT_W-1:0] tgt_act, tgt_nxt, acc_q;
    logic [NS-1:0]            tgt_chg;
    strm_dec_t [NS-1:0]       strm_dec;

    fill_tgt_shadow #(.NS(NS)) u_shadow (
        .clk(clk), .rst(rst), .word_i(tgt_word_i), .mtu_start_i(mtu_start_i),
        .act_o(tgt_act), .nxt_o(tgt_nxt), .chg_o(tgt_chg)
    );

    for (genvar g = 0; g < NS; g++) begin : g_strm
        fill_stream_accum u_acc (
            .clk(clk), .rst(rst), .mtu_start_i(mtu_start_i),
            .tgt_nxt_i(tgt_nxt[g]), .chg_i(tgt_chg[g]),
            .dec_nxt_o(strm_dec[g]), .acc_o(acc_q[g])
        );
    end

    fill_slot_decider #(.NS(NS)) u_dec (
        .clk(clk), .rst(rst), .dec_i(strm_dec),
        .slot_vld_i(slot_vld_i), .slot_strm_i(slot_strm_i), .slot_last_i(slot_last_i),
        .dec_vld_o(dec_vld_o), .dec_strm_o(dec_strm_o), .dec_fill_o(dec_fill_o)
    );
endmodule

// File: rtl/mst_fill_regulator_chk.sv
module mst_fill_regulator_chk
    import fill_reg_pkg::*;
#(
    parameter int NS = NUM_STREAMS,
    localparam int SW = $clog2(NS)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     mtu_start_i,
    input logic                     slot_vld_i,
    input logic [SW-1:0]            slot_strm_i,
    input logic                     slot_last_i,
    input logic                     dec_vld_o,
    input logic [SW-1:0]            dec_strm_o,
    input logic                     dec_fill_o,
    input logic [NS-1:0][TGT_W-1:0] tgt_act,
    input logic [NS-1:0][TGT_W-1:0] tgt_nxt,
    input logic [NS-1:0][TGT_W-1:0] acc_q
);
    assert_dec_follows_slot_R3: assert property (@(posedge clk) disable iff (rst)
        slot_vld_i |=> dec_vld_o && dec_strm_o == $past(slot_strm_i));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        !slot_vld_i |=> !dec_vld_o);

    assert_hold_between_mtu_R4: assert property (@(posedge clk) disable iff (rst)
        !mtu_start_i |=> $stable(tgt_act));

    assert_forced_fill_R5: assert property (@(posedge clk) disable iff (rst)
        slot_vld_i && tgt_nxt[slot_strm_i] > TGT_W'(FULL_SLOT - 1) |=> dec_fill_o);

    assert_zero_target_R6: assert property (@(posedge clk) disable iff (rst)
        slot_vld_i && tgt_nxt[slot_strm_i] == '0 |=> !dec_fill_o);

    assert_nonlast_data_R7: assert property (@(posedge clk) disable iff (rst)
        slot_vld_i && !slot_last_i && tgt_nxt[slot_strm_i] < TGT_W'(FULL_SLOT) |=> !dec_fill_o);

    for (genvar g = 0; g < NS; g++) begin : g_acc
        assert_acc_bound_R7: assert property (@(posedge clk) disable iff (rst)
            acc_q[g] < TGT_W'(FULL_SLOT));
    end
endmodule

bind mst_fill_regulator mst_fill_regulator_chk #(.NS(NS)) u_chk (
    .clk(clk), .rst(rst), .mtu_start_i(mtu_start_i), .slot_vld_i(slot_vld_i),
    .slot_strm_i(slot_strm_i), .slot_last_i(slot_last_i), .dec_vld_o(dec_vld_o),
    .dec_strm_o(dec_strm_o), .dec_fill_o(dec_fill_o), .tgt_act(tgt_act),
    .tgt_nxt(tgt_nxt), .acc_q(acc_q)
);

// File: tb/mst_fill_regulator_tb.sv
module mst_fill_regulator_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tgt_word = 32'h4040_4040;
    logic        mtu = 1'b0, svld = 1'b0, slast = 1'b0;
    logic [1:0]  sstrm = '0;
    logic        dvld, dfill;
    logic [1:0]  dstrm;

    int n_chk = 0, n_bad = 0;
    int m_act[4], m_acc[4];
    bit m_force[4], m_ld[4];
    bit done = 1'b0;

    always #4 clk = ~clk;

    mst_fill_regulator u_dut (
        .clk(clk), .rst(rst), .tgt_word_i(tgt_word), .mtu_start_i(mtu),
        .slot_vld_i(svld), .slot_strm_i(sstrm), .slot_last_i(slast),
        .dec_vld_o(dvld), .dec_strm_o(dstrm), .dec_fill_o(dfill)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_act[i] = 64; m_acc[i] = 0; m_force[i] = 1; m_ld[i] = 0;
        end
    endtask

    task automatic model_mtu(input logic [31:0] w);
        for (int i = 0; i < 4; i++) begin
            int f, b, s;
            f = int'(w[i*8 +: 7]);
            b = (f != m_act[i]) ? 0 : m_acc[i];
            m_act[i] = f;
            m_force[i] = 0; m_ld[i] = 1; m_acc[i] = b;
            if (f > 63) begin
                m_force[i] = 1; m_ld[i] = 0;
            end else if (f != 0) begin
                s = b + f;
                if (s >= 64) begin m_ld[i] = 1; m_acc[i] = s - 64; end
                else begin m_ld[i] = 0; m_acc[i] = s; end
            end
        end
    endtask

    // One cycle: drive at negedge, check the registered decision after the edge.
    task automatic cyc(input bit m, input bit v, input int s, input bit l,
                       input string req, output bit got_fill);
        int ef;
        @(negedge clk);
        mtu = m; svld = v; sstrm = 2'(s); slast = l;
        if (m) model_mtu(tgt_word);
        ef = (m_force[s] || (l && !m_ld[s])) ? 1 : 0;
        @(posedge clk); #1;
        got_fill = dfill;
        chk({req, " vld"}, int'(dvld), v ? 1 : 0);
        if (v) begin
            chk({req, " strm"}, int'(dstrm), s);
            chk({req, " fill"}, int'(dfill), ef);
        end
        @(negedge clk);
        mtu = 0; svld = 0; slast = 0;
    endtask

    task automatic t_reset();
        bit f;
        chk("R2 idle vld", int'(dvld), 0);
        cyc(0, 0, 0, 0, "R3 no slot", f);
        cyc(0, 1, 0, 1, "R2 last slot target64", f);
        cyc(0, 1, 3, 0, "R2 other slot target64", f);
    endtask

    task automatic t_boundary();
        bit f;
        tgt_word = 32'h0;
        cyc(0, 1, 1, 1, "R4 word not yet active", f);
        cyc(1, 1, 1, 1, "R9 slot with mtu start", f);
        cyc(0, 1, 2, 0, "R6 zero target nonlast", f);
        cyc(0, 1, 3, 1, "R6 zero target last", f);
    endtask

    task automatic t_forced();
        bit f;
        tgt_word = 32'h7F_46_40_00;
        cyc(1, 0, 0, 0, "R1 load", f);
        for (int s = 1; s < 4; s++) begin
            cyc(0, 1, s, 1, "R5 last", f);
            cyc(0, 1, s, 0, "R5 nonlast", f);
        end
        cyc(0, 1, 0, 1, "R1 R6 stream0 field", f);
    endtask

    task automatic t_mixed();
        bit f;
        tgt_word = {8'd63, 8'd32, 8'd1, 8'd20};
        for (int k = 0; k < 8; k++) begin
            cyc(1, 0, 0, 0, "R7 mtu", f);
            for (int s = 0; s < 4; s++) begin
                cyc(0, 1, s, 0, "R7 nonlast", f);
                cyc(0, 1, s, 1, "R7 last", f);
            end
        end
    endtask

    task automatic t_clear();
        bit f;
        tgt_word[15:8] = 8'd33;
        cyc(1, 1, 1, 1, "R8 first mtu at 33", f);
        tgt_word[15:8] = 8'd40;
        cyc(1, 1, 1, 1, "R8 changed field restarts", f);
        chk("R8 fill after restart", int'(f), 1);
        cyc(0, 1, 0, 1, "R8 unchanged stream keeps", f);
        tgt_word = tgt_word | 32'h8080_8080;
        cyc(1, 1, 1, 1, "R1 reserved bits ignored", f);
        chk("R1 acc kept 40+40", int'(f), 0);
        for (int s = 0; s < 4; s++) cyc(0, 1, s, 1, "R1 reserved bits", f);
    endtask

    task automatic t_longrun();
        bit f;
        int data_cnt = 0;
        tgt_word[23:16] = 8'd45;
        for (int k = 0; k < 64; k++) begin
            cyc(1, 1, 2, 1, "R10 step", f);
            if (!f) data_cnt++;
        end
        chk("R10 data count", data_cnt, 45);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_boundary();
        t_forced();
        t_mixed();
        t_clear();
        t_longrun();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule